// File: doc/BRIEF.md
# NAND ECC Engine Register Front End

This block is the register front end of a NAND flash error-correction engine that has two channels, an encoder and a decoder. Software reaches it through a simple single-cycle register bus. It holds, for each channel, a run control bit, a configuration word, an idle indication, an interrupt-enable word and a sticky interrupt status bit. The decoder also has a per-sector completion register. The arithmetic core sits behind the block. The block drives that core with run, strength, mode and codeword-size signals, and it receives busy, step-done and step-index (sector number) pulses back from it.

The block converts the stored strength index into a correction strength in bits. From the configured data length it computes the codeword size in bits: data only for the encoder, and data plus parity for the decoder. It merges all enabled status bits into one interrupt line. When page mode is selected, the per-step interrupt events are collapsed into a single event at the last sector of the page.

Encoder registers sit at byte address 0x000 and decoder registers at 0x100. Inside each group, the offsets are control 0x00, configuration 0x04, idle 0x0C, interrupt enable 0x10 and interrupt status 0x14. Offset 0x18 of the decoder group holds the per-sector done register.

Top module: `nand_ecc_regs`

## Requirements
- R1: After reset, both run bits, configuration words, interrupt enables, status bits and done bits are 0, and `irq` is low.
- R2: A write to a control word with bit 0 set starts that channel (`encRun`/`decRun` high), and a write with bit 0 clear stops it. The control word reads back the run bit in bit 0. Step pulses arriving while a channel is stopped have no effect on its status or done bits.
- R3: Bit 0 of an idle word reads 1 exactly when that channel's busy input is low.
- R4: Configuration fields are: strength index in bits 4:0, mode in bits 6:5, last sector index in bits 10:7, data length in bytes in bits 27:16. Unused bits read 0. A configuration write is ignored while its channel is running.
- R5: A start request is refused (the run bit stays 0) when the stored strength index is 20 or more.
- R6: Strength is 4+2*i for index i up to 10, and 24+4*(i-10) above that. The encoder codeword size is length*8. The decoder codeword size is length*8 + strength*14.
- R7: Interrupt enable bit 0 gates the channel's status into `irq`. In step mode (enable bit 1 clear) every step-done pulse of a running channel sets the status bit, even when bit 0 is clear.
- R8: In page mode (enable bit 1 set), status is set only by the step whose index equals the configured last sector index.
- R9: Reading a status word returns the status in bit 0 and clears it in the same access.
- R10: The decoder done register sets bit k when a decoder step with index k completes, and reading it returns the bits and clears them.
- R11: The decoder configuration also carries a correction mode in bits 13:12 (driven on `decCorrect`) and an empty-page enable in bit 31 (driven on `decEmptyEn`). The encoder configuration stores neither field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Register access this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 9 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| encBusy | input | 1 | Encoder core busy |
| encStepDone | input | 1 | Encoder step completed (one-cycle pulse) |
| encStepIdx | input | 4 | Sector index of the encoder step |
| decBusy | input | 1 | Decoder core busy |
| decStepDone | input | 1 | Decoder step completed (one-cycle pulse) |
| decStepIdx | input | 4 | Sector index of the decoder step |
| encRun | output | 1 | Encoder enabled |
| encStrength | output | 7 | Encoder correction strength in bits |
| encMode | output | 2 | Encoder mode field |
| encMsgBits | output | 16 | Encoder codeword size in bits |
| decRun | output | 1 | Decoder enabled |
| decStrength | output | 7 | Decoder correction strength in bits |
| decMode | output | 2 | Decoder mode field |
| decMsgBits | output | 16 | Decoder codeword size in bits |
| decCorrect | output | 2 | Decoder correction mode |
| decEmptyEn | output | 1 | Decoder empty-page enable |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong run bit shows at `encRun`/`decRun` one clock after the control write. If a step event is missed, the interrupt goes missing; if the status is not cleared, the interrupt stays stuck. Either fault appears on `irq` one clock after the step pulse or after the status read. A bad page-mode gate raises `irq` on an early sector, or never raises it. A wrong done bit shows up on the first read of the done register. An error in the strength or length arithmetic reaches the codeword-size outputs as soon as the configuration write lands.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int NumCh     = 2;
  localparam int BusAddrW  = 9;
  localparam int StrIdxW   = 5;
  localparam int SectIdxW  = 4;
  localparam int StrengthW = 7;
  localparam int CfgModeLo  = 5;
  localparam int CfgLastLo  = 7;
  localparam int CfgCorrLo  = 12;
  localparam int CfgLenLo   = 16;
  localparam int CfgEmptyBit = 31;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTL, SEL_CFG, SEL_IDLE, SEL_IRQEN, SEL_STA, SEL_DONE
  } rdSel_e;

  typedef struct packed {
    logic wrCtl;
    logic wrCfg;
    logic wrIrqEn;
    logic rdSta;
  } chStrb_t;

  typedef struct packed {
    chStrb_t [NumCh-1:0] ch;
    logic                rdDone;
    rdSel_e              sel;
    logic                chSel;
  } regStrb_t;

  // index -> correction bits: steps of 2 up to index 10, then steps of 4
  function automatic logic [StrengthW-1:0] strengthOf(input logic [StrIdxW-1:0] idx);
    if (idx <= 5'd10) return 7'd4 + {1'b0, idx, 1'b0};
    return 7'd24 + {idx - 5'd10, 2'b00};
  endfunction
endpackage

// File: rtl/ecc_reg_ctrl.sv
module ecc_reg_ctrl
  import nand_ecc_pkg::*;
(
  input  logic                busSel,
  input  logic                busWr,
  input  logic [BusAddrW-1:0] busAddr,
  output regStrb_t            strb
);
  logic   chSel;
  logic   rdEn;
  logic   wrEn;
  rdSel_e sel;

  always_comb begin
    chSel = busAddr[BusAddrW-1];
    rdEn  = busSel & ~busWr;
    wrEn  = busSel & busWr;
    case (busAddr[7:0])
      8'h00:   sel = SEL_CTL;
      8'h04:   sel = SEL_CFG;
      8'h0C:   sel = SEL_IDLE;
      8'h10:   sel = SEL_IRQEN;
      8'h14:   sel = SEL_STA;
      8'h18:   sel = chSel ? SEL_DONE : SEL_NONE;
      default: sel = SEL_NONE;
    endcase
    strb        = '0;
    strb.chSel  = chSel;
    strb.sel    = rdEn ? sel : SEL_NONE;
    strb.rdDone = rdEn && (sel == SEL_DONE);
    for (int c = 0; c < NumCh; c++) begin
      strb.ch[c].wrCtl   = wrEn && (sel == SEL_CTL)   && (int'(chSel) == c);
      strb.ch[c].wrCfg   = wrEn && (sel == SEL_CFG)   && (int'(chSel) == c);
      strb.ch[c].wrIrqEn = wrEn && (sel == SEL_IRQEN) && (int'(chSel) == c);
      strb.ch[c].rdSta   = rdEn && (sel == SEL_STA)   && (int'(chSel) == c);
    end
  end
endmodule

// File: rtl/ecc_reg_datapath.sv
module ecc_reg_datapath
  import nand_ecc_pkg::*;
#(
  parameter int LenW          = 12,
  parameter int StrengthCount = 20,
  parameter int ParityBits    = 14,
  parameter int MsgW          = LenW + 4
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  regStrb_t                              strb,
  input  logic [31:0]                           wdata,
  input  logic [NumCh-1:0]                      busyIn,
  input  logic [NumCh-1:0]                      stepDone,
  input  logic [NumCh-1:0][SectIdxW-1:0]        stepIdx,
  output logic [31:0]                           rdata,
  output logic [NumCh-1:0]                      runOut,
  output logic [NumCh-1:0][31:0]                cfgOut,
  output logic [NumCh-1:0][StrengthW-1:0]       strengthOut,
  output logic [NumCh-1:0][MsgW-1:0]            msgBitsOut,
  output logic                                  irq
);
  localparam int SectN = 2 ** SectIdxW;
  localparam logic [31:0] LenMask  = 32'(((64'd1 << LenW) - 64'd1) << CfgLenLo);
  localparam logic [31:0] BaseMask = 32'h0000_07FF | LenMask;
  localparam logic [31:0] DecExtra = 32'h8000_3000;

  logic [NumCh-1:0]       staQ;
  logic [NumCh-1:0][1:0]  enQ;
  logic [SectN-1:0]       doneQ;

  for (genvar ch = 0; ch < NumCh; ch++) begin : g_ch
    localparam logic [31:0] Mask = (ch == 0) ? BaseMask : (BaseMask | DecExtra);
    logic        runR;
    logic        staR;
    logic [1:0]  enR;
    logic [31:0] cfgR;
    logic        stepHit;
    logic        lastHit;
    logic        staSet;
    logic        idxOk;
    logic [MsgW-1:0] dataBits;

    assign idxOk   = int'(cfgR[StrIdxW-1:0]) < StrengthCount;
    assign stepHit = runR && stepDone[ch];
    assign lastHit = stepHit && (stepIdx[ch] == cfgR[CfgLastLo +: SectIdxW]);
    assign staSet  = enR[1] ? lastHit : stepHit;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runR <= 1'b0;
        staR <= 1'b0;
        enR  <= '0;
        cfgR <= '0;
      end else begin
        if (strb.ch[ch].wrCtl) runR <= wdata[0] && idxOk;
        if (strb.ch[ch].wrCfg && !runR) cfgR <= wdata & Mask;
        if (strb.ch[ch].wrIrqEn) enR <= wdata[1:0];
        if (staSet) staR <= 1'b1;
        else if (strb.ch[ch].rdSta) staR <= 1'b0;
      end
    end

    assign dataBits        = {(MsgW - LenW - 3)'(0), cfgR[CfgLenLo +: LenW], 3'b000};
    assign strengthOut[ch] = strengthOf(cfgR[StrIdxW-1:0]);
    if (ch == 0) begin : g_enc
      assign msgBitsOut[ch] = dataBits;
    end else begin : g_dec
      assign msgBitsOut[ch] = dataBits + MsgW'(strengthOut[ch]) * MsgW'(ParityBits);
    end

    assign runOut[ch] = runR;
    assign cfgOut[ch] = cfgR;
    assign staQ[ch]   = staR;
    assign enQ[ch]    = enR;

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(runR) && runR) |-> $stable(cfgR));
    // R5
    bad_start_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(runR) |-> (int'(cfgR[StrIdxW-1:0]) < StrengthCount));
    // R2
    stop_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ch[ch].wrCtl && !wdata[0]) |=> !runR);
    // R9
    sta_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strb.ch[ch].rdSta && !stepDone[ch]) |=> !staR);
  end

  // decoder per-sector completion
  logic [SectN-1:0] doneSet;
  assign doneSet = (runOut[1] && stepDone[1]) ? (SectN'(1) << stepIdx[1]) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) doneQ <= '0;
    else       doneQ <= (strb.rdDone ? '0 : doneQ) | doneSet;
  end

  // R8
  page_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(staQ[1]) && enQ[1][1] && $stable(enQ[1]))
      |-> doneQ[cfgOut[1][CfgLastLo +: SectIdxW]]);

  always_comb begin
    rdata = '0;
    case (strb.sel)
      SEL_CTL:   rdata[0]   = runOut[strb.chSel];
      SEL_CFG:   rdata      = cfgOut[strb.chSel];
      SEL_IDLE:  rdata[0]   = ~busyIn[strb.chSel];
      SEL_IRQEN: rdata[1:0] = enQ[strb.chSel];
      SEL_STA:   rdata[0]   = staQ[strb.chSel];
      SEL_DONE:  rdata[SectN-1:0] = doneQ;
      default:   rdata      = '0;
    endcase
  end

  assign irq = (staQ[0] & enQ[0][0]) | (staQ[1] & enQ[1][0]);
endmodule

// File: rtl/nand_ecc_regs.sv
module nand_ecc_regs
  import nand_ecc_pkg::*;
#(
  parameter int LenW          = 12,
  parameter int StrengthCount = 20,
  parameter int ParityBits    = 14,
  parameter int MsgW          = LenW + 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [BusAddrW-1:0]  busAddr,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic                 encBusy,
  input  logic                 encStepDone,
  input  logic [SectIdxW-1:0]  encStepIdx,
  input  logic                 decBusy,
  input  logic                 decStepDone,
  input  logic [SectIdxW-1:0]  decStepIdx,
  output logic                 encRun,
  output logic [StrengthW-1:0] encStrength,
  output logic [1:0]           encMode,
  output logic [MsgW-1:0]      encMsgBits,
  output logic                 decRun,
  output logic [StrengthW-1:0] decStrength,
  output logic [1:0]           decMode,
  output logic [MsgW-1:0]      decMsgBits,
  output logic [1:0]           decCorrect,
  output logic                 decEmptyEn,
  output logic                 irq
);
  regStrb_t                        strb;
  logic [NumCh-1:0]                runOut;
  logic [NumCh-1:0][31:0]          cfgOut;
  logic [NumCh-1:0][StrengthW-1:0] strengthOut;
  logic [NumCh-1:0][MsgW-1:0]      msgBitsOut;

  ecc_reg_ctrl ctrl_i (
    .busSel (busSel),
    .busWr  (busWr),
    .busAddr(busAddr),
    .strb   (strb)
  );

  ecc_reg_datapath #(
    .LenW(LenW), .StrengthCount(StrengthCount), .ParityBits(ParityBits), .MsgW(MsgW)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (busWdata),
    .busyIn     ({decBusy, encBusy}),
    .stepDone   ({decStepDone, encStepDone}),
    .stepIdx    ({decStepIdx, encStepIdx}),
    .rdata      (busRdata),
    .runOut     (runOut),
    .cfgOut     (cfgOut),
    .strengthOut(strengthOut),
    .msgBitsOut (msgBitsOut),
    .irq        (irq)
  );

  assign encRun      = runOut[0];
  assign decRun      = runOut[1];
  assign encStrength = strengthOut[0];
  assign decStrength = strengthOut[1];
  assign encMode     = cfgOut[0][CfgModeLo +: 2];
  assign decMode     = cfgOut[1][CfgModeLo +: 2];
  assign encMsgBits  = msgBitsOut[0];
  assign decMsgBits  = msgBitsOut[1];
  assign decCorrect  = cfgOut[1][CfgCorrLo +: 2];
  assign decEmptyEn  = cfgOut[1][CfgEmptyBit];
endmodule

// File: tb/nand_ecc_regs_tb.sv
module nand_ecc_regs_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [8:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic encBusy = 1'b0, encStepDone = 1'b0, decBusy = 1'b0, decStepDone = 1'b0;
  logic [3:0] encStepIdx = '0, decStepIdx = '0;
  logic encRun, decRun, decEmptyEn, irq;
  logic [6:0] encStrength, decStrength;
  logic [1:0] encMode, decMode, decCorrect;
  logic [15:0] encMsgBits, decMsgBits;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  nand_ecc_regs dut_i (.*);

  localparam logic [8:0] ENC = 9'h000, DEC = 9'h100;
  localparam logic [8:0] O_CTL = 9'h00, O_CFG = 9'h04, O_IDLE = 9'h0C,
                         O_EN = 9'h10, O_STA = 9'h14, O_DONE = 9'h18;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic step(input bit dec, input logic [3:0] idx);
    @(negedge clk);
    if (dec) begin decStepDone = 1'b1; decStepIdx = idx; end
    else     begin encStepDone = 1'b1; encStepIdx = idx; end
    @(negedge clk);
    decStepDone = 1'b0; encStepDone = 1'b0;
  endtask

  function automatic logic [31:0] cfgWord(input int idx, input int mode, input int last,
                                          input int corr, input int len, input bit empty);
    return (32'(empty) << 31) | (32'(len) << 16) | (32'(corr) << 12) |
           (32'(last) << 7) | (32'(mode) << 5) | 32'(idx);
  endfunction

  task automatic testReset();
    logic [31:0] d;
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 encRun", {31'b0, encRun}, 0);
    rd(ENC | O_CTL, d); chk("R1 enc ctl", d, 0);
    rd(DEC | O_CFG, d); chk("R1 dec cfg", d, 0);
    rd(DEC | O_STA, d); chk("R1 dec sta", d, 0);
    rd(DEC | O_DONE, d); chk("R1 done", d, 0);
    rd(ENC | O_IDLE, d); chk("R3 idle not busy", d, 1);
  endtask

  task automatic testConfig();
    logic [31:0] d;
    wr(ENC | O_CFG, cfgWord(3, 1, 2, 3, 512, 1'b1));
    rd(ENC | O_CFG, d); chk("R11 enc cfg drops dec fields", d, cfgWord(3, 1, 2, 0, 512, 1'b0));
    chk("R6 enc strength", 32'(encStrength), 10);
    chk("R6 enc bits", 32'(encMsgBits), 4096);
    chk("R4 enc mode", 32'(encMode), 1);
    wr(DEC | O_CFG, cfgWord(12, 2, 3, 3, 1024, 1'b1));
    rd(DEC | O_CFG, d); chk("R4 dec cfg readback", d, cfgWord(12, 2, 3, 3, 1024, 1'b1));
    chk("R6 dec strength", 32'(decStrength), 32);
    chk("R6 dec bits", 32'(decMsgBits), 8640);
    chk("R11 correct", 32'(decCorrect), 3);
    chk("R11 empty", {31'b0, decEmptyEn}, 1);
    wr(ENC | O_CFG, cfgWord(7, 0, 0, 0, 100, 1'b0));
    chk("R6 enc strength idx7", 32'(encStrength), 18);
    chk("R6 enc bits 100", 32'(encMsgBits), 800);
  endtask

  task automatic testRunIdle();
    logic [31:0] d;
    wr(ENC | O_CTL, 1);
    chk("R2 encRun start", {31'b0, encRun}, 1);
    rd(ENC | O_CTL, d); chk("R2 ctl readback", d, 1);
    wr(ENC | O_CFG, cfgWord(2, 3, 0, 0, 40, 1'b0));
    rd(ENC | O_CFG, d); chk("R4 cfg ignored while running", d, cfgWord(7, 0, 0, 0, 100, 1'b0));
    chk("R4 strength unchanged", 32'(encStrength), 18);
    @(negedge clk) encBusy = 1'b1;
    rd(ENC | O_IDLE, d); chk("R3 idle busy", d, 0);
    @(negedge clk) encBusy = 1'b0;
    wr(ENC | O_CTL, 0);
    chk("R2 encRun stop", {31'b0, encRun}, 0);
  endtask

  task automatic testBadIndex();
    wr(ENC | O_CFG, cfgWord(20, 0, 0, 0, 16, 1'b0));
    wr(ENC | O_CTL, 1);
    chk("R5 idx20 blocked", {31'b0, encRun}, 0);
    wr(ENC | O_CFG, cfgWord(19, 0, 2, 0, 16, 1'b0));
    chk("R6 idx19 strength", 32'(encStrength), 60);
    wr(ENC | O_CTL, 1);
    chk("R5 idx19 starts", {31'b0, encRun}, 1);
  endtask

  task automatic testStepIrq();
    logic [31:0] d;
    wr(ENC | O_EN, 1);
    step(1'b0, 4'd0);
    chk("R7 irq on step", {31'b0, irq}, 1);
    rd(ENC | O_STA, d); chk("R9 sta read", d, 1);
    chk("R9 irq cleared", {31'b0, irq}, 0);
    rd(ENC | O_STA, d); chk("R9 sta cleared", d, 0);
    wr(ENC | O_EN, 0);
    step(1'b0, 4'd1);
    chk("R7 masked irq", {31'b0, irq}, 0);
    rd(ENC | O_STA, d); chk("R7 sta sets unmasked", d, 1);
    wr(ENC | O_CTL, 0);
  endtask

  task automatic testPage();
    logic [31:0] d;
    wr(DEC | O_EN, 3);
    wr(DEC | O_CTL, 1);
    chk("R2 decRun", {31'b0, decRun}, 1);
    for (int k = 0; k < 3; k++) step(1'b1, 4'(k));
    chk("R8 no irq before last", {31'b0, irq}, 0);
    step(1'b1, 4'd3);
    chk("R8 irq at last", {31'b0, irq}, 1);
    rd(DEC | O_DONE, d); chk("R10 done bits", d, 32'hF);
    rd(DEC | O_DONE, d); chk("R10 done cleared", d, 0);
    rd(DEC | O_STA, d); chk("R9 dec sta", d, 1);
    chk("R9 dec irq low", {31'b0, irq}, 0);
    wr(DEC | O_EN, 1);
    step(1'b1, 4'd5);
    chk("R7 dec step mode irq", {31'b0, irq}, 1);
    rd(DEC | O_DONE, d); chk("R10 done bit5", d, 32'h20);
    rd(DEC | O_STA, d);
    wr(DEC | O_CTL, 0);
    step(1'b1, 4'd2);
    rd(DEC | O_DONE, d); chk("R2 stopped ignores step done", d, 0);
    rd(DEC | O_STA, d); chk("R2 stopped ignores step sta", d, 0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testConfig();
    testRunIdle();
    testBadIndex();
    testStepIrq();
    testPage();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end
endmodule